// File: doc/BRIEF.md
# Sequential Signed Q32.32 Divider

This block divides one signed fixed-point number by another. Both operands and the quotient use the Q32.32 format: 64-bit two's complement with 32 fractional bits. A caller pulses `start_i` with the dividend, the divisor and a rounding select. The block then works for a fixed number of cycles and reports the result with a one-cycle `done_o` pulse. The quotient, the overflow flag and the divide-by-zero flag stay on the outputs until the next result arrives.

The division runs on magnitudes. The dividend magnitude is scaled by 2^32 into a 128-bit partial register, so the integer quotient carries 32 fractional bits. The magnitude then goes through one restoring shift-subtract step per clock. The sign is applied at the end. Overflow is decided from the scaled dividend before the iterations start, and again on the final magnitude when it does not fit the signed range. In either case the quotient saturates toward the sign of the true result.

Top module: `q32_divider`

## Requirements
- R1: After reset, `busy_o`, `done_o`, `quot_o`, `ovf_o` and `dz_o` are all 0.
- R2: When no overflow occurs, `quot_o` is the exact quotient dividend*2^32/divisor of the raw integers, truncated toward zero. It is negative exactly when the sign bits of the two operands differ and the quotient is nonzero.
- R3: When the upper 64 bits of the scaled dividend magnitude (|dividend|*2^32, plus any rounding term) are greater than or equal to |divisor|, `ovf_o` is 1. `quot_o` is then 0x7FFF_FFFF_FFFF_FFFF if the operand signs match and 0x8000_0000_0000_0000 if they differ.
- R4: A zero divisor sets both `dz_o` and `ovf_o`. `quot_o` then saturates by the sign of the dividend: the maximum value for a non-negative dividend, the minimum value for a negative one.
- R5: When the unsigned quotient does not fit the signed range, `ovf_o` is set and `quot_o` saturates as in R3. The range is at most 2^63-1 for a positive result and at most 2^63 for a negative one. A negative result of exactly 2^63 gives 0x8000_0000_0000_0000 with `ovf_o` at 0.
- R6: With `round_i` at 1 on the start cycle, floor(|divisor|/2) is added to the scaled dividend magnitude before the overflow test and the division. The magnitude is thus rounded half up.
- R7: `done_o` is high for exactly one cycle, 66 rising edges after the edge that accepts `start_i`. `busy_o` is high from the accepting edge until `done_o` rises and is low while `done_o` is high. `quot_o` changes only when `done_o` rises.
- R8: The operands and `round_i` are captured on the accepting edge. Later changes to them have no effect. A `start_i` pulse while `busy_o` is high is ignored: it produces no extra result and does not alter the running one.
- R9: A `start_i` pulse in the cycle in which `done_o` is high is accepted as a new operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Begin a division when idle |
| dividend_i | input | 64 | Signed Q32.32 dividend |
| divisor_i | input | 64 | Signed Q32.32 divisor |
| round_i | input | 1 | 1 = round the quotient magnitude half up |
| busy_o | output | 1 | Division in progress |
| done_o | output | 1 | One-cycle pulse: result valid |
| quot_o | output | 64 | Signed Q32.32 quotient, held until the next result |
| ovf_o | output | 1 | Quotient saturated |
| dz_o | output | 1 | Divisor was zero |

## Verification
Two events can fall in the same cycle: the result of one division appearing on `done_o`, and a new `start_i` being accepted. The bench provokes this by raising `start_i` on the very cycle its monitor sees `done_o`. The scoreboard must then pop the first result intact. It must also later receive the second operation's own quotient, exactly 66 edges after that start was accepted. A second pair is also driven: a start pulse issued in the middle of a run with other operands. It is judged correct only if no result appears for it and the running result still matches its original operands.

// File: rtl/q32_div_pkg.sv
package q32_div_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SETUP = 2'd1,
    ST_RUN   = 2'd2,
    ST_FIX   = 2'd3
  } div_state_e;
endpackage

// File: rtl/q32_sign_prep.sv
module q32_sign_prep #(
  parameter int W = 64
) (
  input  logic [W-1:0] num_i,
  input  logic [W-1:0] den_i,
  output logic [W-1:0] num_mag_o,
  output logic [W-1:0] den_mag_o,
  output logic         neg_o
);
  assign num_mag_o = num_i[W-1] ? (~num_i + {{(W-1){1'b0}}, 1'b1}) : num_i;
  assign den_mag_o = den_i[W-1] ? (~den_i + {{(W-1){1'b0}}, 1'b1}) : den_i;
  assign neg_o     = num_i[W-1] ^ den_i[W-1];
endmodule

// File: rtl/q32_div_step.sv
module q32_div_step #(
  parameter int W = 64
) (
  input  logic [2*W-1:0] rem_i,
  input  logic [W-1:0]   den_i,
  output logic [2*W-1:0] rem_o
);
  // upper half after the shift, keeping the bit that leaves the top
  logic [W:0] top_w;
  logic [W:0] diff_w;
  logic       ge;

  assign top_w  = rem_i[2*W-1:W-1];
  assign diff_w = top_w - {1'b0, den_i};
  assign ge     = (top_w >= {1'b0, den_i});
  assign rem_o  = ge ? {diff_w[W-1:0], rem_i[W-2:0], 1'b1}
                     : {top_w[W-1:0], rem_i[W-2:0], 1'b0};
endmodule

// File: rtl/q32_sign_fix.sv
module q32_sign_fix #(
  parameter int W = 64
) (
  input  logic [W-1:0] uq_i,
  input  logic         neg_i,
  input  logic         pre_ovf_i,
  output logic [W-1:0] q_o,
  output logic         ovf_o
);
  localparam logic [W-1:0] MAXV = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] MINV = {1'b1, {(W-1){1'b0}}};

  logic range_bad;

  assign range_bad = neg_i ? (uq_i > MINV) : uq_i[W-1];
  assign ovf_o     = pre_ovf_i | range_bad;
  assign q_o       = ovf_o ? (neg_i ? MINV : MAXV)
                           : (neg_i ? (~uq_i + {{(W-1){1'b0}}, 1'b1}) : uq_i);
endmodule

// File: rtl/q32_divider.sv
module q32_divider
  import q32_div_pkg::*;
#(
  parameter int INT_W  = 32,
  parameter int FRAC_W = 32
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      start_i,
  input  logic [INT_W+FRAC_W-1:0]   dividend_i,
  input  logic [INT_W+FRAC_W-1:0]   divisor_i,
  input  logic                      round_i,
  output logic                      busy_o,
  output logic                      done_o,
  output logic [INT_W+FRAC_W-1:0]   quot_o,
  output logic                      ovf_o,
  output logic                      dz_o
);
  localparam int W     = INT_W + FRAC_W;
  localparam int CNT_W = $clog2(W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(W - 1);

  // reset: asserted asynchronously, released through two flops
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  div_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q;
  logic [W-1:0]     num_q, den_q;
  logic             rnd_q;
  logic [2*W-1:0]   rem_q;
  logic             povf_q, dz_q;
  logic             done_q, ovf_q, dzo_q;
  logic [W-1:0]     quot_q;

  logic cap_en, ld_en, run_en, fix_en;

  logic [W-1:0]   num_mag, den_mag;
  logic           neg;
  logic [2*W-1:0] ext_base, ext_rnd, rem_step;
  logic [W-1:0]   fix_q;
  logic           fix_ovf;

  q32_sign_prep #(.W(W)) u_prep (
    .num_i     (num_q),
    .den_i     (den_q),
    .num_mag_o (num_mag),
    .den_mag_o (den_mag),
    .neg_o     (neg)
  );

  assign ext_base = {{W{1'b0}}, num_mag} << FRAC_W;
  assign ext_rnd  = ext_base + (rnd_q ? {{(W+1){1'b0}}, den_mag[W-1:1]}
                                      : {(2*W){1'b0}});

  q32_div_step #(.W(W)) u_step (
    .rem_i (rem_q),
    .den_i (den_mag),
    .rem_o (rem_step)
  );

  q32_sign_fix #(.W(W)) u_fix (
    .uq_i      (rem_q[W-1:0]),
    .neg_i     (neg),
    .pre_ovf_i (povf_q),
    .q_o       (fix_q),
    .ovf_o     (fix_ovf)
  );

  // next state and enables
  always_comb begin
    state_d = state_q;
    cap_en  = 1'b0;
    ld_en   = 1'b0;
    run_en  = 1'b0;
    fix_en  = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          cap_en  = 1'b1;
          state_d = ST_SETUP;
        end
      end
      ST_SETUP: begin
        ld_en   = 1'b1;
        state_d = ST_RUN;
      end
      ST_RUN: begin
        run_en = 1'b1;
        if (cnt_q == LAST) state_d = ST_FIX;
      end
      ST_FIX: begin
        fix_en  = 1'b1;
        state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // control and output registers
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      done_q  <= 1'b0;
      quot_q  <= '0;
      ovf_q   <= 1'b0;
      dzo_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= fix_en;
      if (ld_en)       cnt_q <= '0;
      else if (run_en) cnt_q <= cnt_q + 1'b1;
      if (fix_en) begin
        quot_q <= fix_q;
        ovf_q  <= fix_ovf;
        dzo_q  <= dz_q;
      end
    end
  end

  // datapath registers, no reset
  always_ff @(posedge clk) begin
    if (cap_en) begin
      num_q <= dividend_i;
      den_q <= divisor_i;
      rnd_q <= round_i;
    end
    if (ld_en) begin
      povf_q <= (ext_rnd[2*W-1:W] >= den_mag);
      dz_q   <= (den_mag == '0);
    end
    if (ld_en)       rem_q <= ext_rnd;
    else if (run_en) rem_q <= rem_step;
  end

  assign busy_o = (state_q != ST_IDLE);
  assign done_o = done_q;
  assign quot_o = quot_q;
  assign ovf_o  = ovf_q;
  assign dz_o   = dzo_q;
endmodule

// File: rtl/q32_divider_chk.sv
module q32_divider_chk #(
  parameter int W = 64
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start_i,
  input logic         busy_o,
  input logic         done_o,
  input logic [W-1:0] quot_o,
  input logic         ovf_o,
  input logic         dz_o
);
  localparam int LAT = W + 2;
  localparam int LW  = $clog2(LAT + 2);
  localparam logic [W-1:0] MAXV = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] MINV = {1'b1, {(W-1){1'b0}}};

  logic [LW-1:0] lat_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  lat_q <= '0;
    else if (start_i && !busy_o) lat_q <= '0;
    else if (busy_o)             lat_q <= lat_q + 1'b1;
  end

  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  assert_done_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);
  assert_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (lat_q == LW'(LAT)));
  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> $stable(quot_o));
  assert_dz_ovf_R4: assert property (@(posedge clk) disable iff (!rst_n)
    dz_o |-> ovf_o);
  assert_sat_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_o |-> (quot_o == MAXV || quot_o == MINV));
  assert_busy_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> $past(start_i));
endmodule

bind q32_divider q32_divider_chk #(.W(W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .start_i (start_i),
  .busy_o  (busy_o),
  .done_o  (done_o),
  .quot_o  (quot_o),
  .ovf_o   (ovf_o),
  .dz_o    (dz_o)
);

// File: tb/q32_divider_bench.sv
module q32_divider_bench;
  localparam logic [63:0] MAXV = 64'h7FFF_FFFF_FFFF_FFFF;
  localparam logic [63:0] MINV = 64'h8000_0000_0000_0000;
  localparam logic [63:0] ONE  = 64'h0000_0001_0000_0000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start_i;
  logic [63:0] dvd, dvs;
  logic        rnd;
  logic        busy, done, ovf, dz;
  logic [63:0] quot;

  always #4 clk = ~clk;

  q32_divider u_q32_divider (
    .clk(clk), .rst_n(rst_n), .start_i(start_i),
    .dividend_i(dvd), .divisor_i(dvs), .round_i(rnd),
    .busy_o(busy), .done_o(done), .quot_o(quot), .ovf_o(ovf), .dz_o(dz)
  );

  typedef struct {
    logic [63:0] q;
    logic        ovf;
    logic        dz;
    int unsigned t;
  } exp_t;

  exp_t  sb_q[$];
  string tag_q[$];
  int unsigned cyc = 0;
  int errors = 0;
  int checks = 0;
  bit finished = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic exp_t model(logic [63:0] a, logic [63:0] b, logic r);
    exp_t e;
    logic neg;
    logic [63:0] am, bm, u;
    logic [127:0] ext, uq;
    neg = a[63] ^ b[63];
    am = a[63] ? -a : a;
    bm = b[63] ? -b : b;
    ext = {64'd0, am} << 32;
    if (r) ext = ext + {64'd0, bm >> 1};
    e.dz = (bm == 64'd0);
    e.ovf = 1'b0;
    e.q = 64'd0;
    e.t = 0;
    if (e.dz || ext[127:64] >= bm) begin
      e.ovf = 1'b1;
      e.q = neg ? MINV : MAXV;
    end else begin
      uq = ext / {64'd0, bm};
      u = uq[63:0];
      if ((!neg && u[63]) || (neg && u > MINV)) begin
        e.ovf = 1'b1;
        e.q = neg ? MINV : MAXV;
      end else begin
        e.q = neg ? -u : u;
      end
    end
    return e;
  endfunction

  // driver: called at a falling edge, returns one falling edge later
  task automatic issue(logic [63:0] a, logic [63:0] b, logic r, string tag);
    exp_t e;
    dvd = a; dvs = b; rnd = r; start_i = 1'b1;
    e = model(a, b, r);
    e.t = cyc;
    sb_q.push_back(e);
    tag_q.push_back(tag);
    @(negedge clk);
    start_i = 1'b0;
    dvd = ~a; dvs = a ^ b; rnd = ~r;   // R8: later input changes must not matter
  endtask

  task automatic wait_done();
    do @(negedge clk); while (!done);
  endtask

  task automatic go(logic [63:0] a, logic [63:0] b, logic r, string tag);
    issue(a, b, r, tag);
    wait_done();
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n && done) begin
      if (sb_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R8 unexpected result: actual=%h expected=none", quot);
      end else begin
        exp_t e;
        string tg;
        e = sb_q.pop_front();
        tg = tag_q.pop_front();
        chk(tg, "quotient", quot, e.q);
        chk(tg, "overflow", {63'd0, ovf}, {63'd0, e.ovf});
        chk(tg, "div-by-zero", {63'd0, dz}, {63'd0, e.dz});
        chk("R7", "latency", 64'(cyc - e.t), 64'd67);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [63:0] s;
    rst_n = 1'b0; start_i = 1'b0; dvd = '0; dvs = '0; rnd = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", "busy", {63'd0, busy}, 64'd0);
    chk("R1", "done", {63'd0, done}, 64'd0);
    chk("R1", "quot", quot, 64'd0);
    chk("R1", "flags", {62'd0, ovf, dz}, 64'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1", "busy after release", {63'd0, busy}, 64'd0);

    // R2 plain signed division
    go(ONE, ONE, 1'b0, "R2");
    go(64'h0000_0001_8000_0000, 64'h0000_0000_8000_0000, 1'b0, "R2");
    go(-64'h0000_0007_0000_0000, 64'h0000_0002_0000_0000, 1'b0, "R2");
    go(-64'h0000_0007_0000_0000, -64'h0000_0002_0000_0000, 1'b0, "R2");
    go(64'h0000_0000_0000_0001, -64'h0000_0003_0000_0000, 1'b0, "R2");
    // R4 zero divisor
    go(ONE, 64'd0, 1'b0, "R4");
    go(-ONE, 64'd0, 1'b1, "R4");
    // R3 up-front overflow, including the equality boundary
    go(64'h0100_0000_0000_0000, 64'd1, 1'b0, "R3");
    go(64'h0100_0000_0000_0000, -64'd1, 1'b0, "R3");
    go(64'h0000_0005_0000_0000, 64'd5, 1'b0, "R3");
    // R5 range of the signed result
    go(64'h0000_0005_0000_0000, 64'd6, 1'b0, "R5");
    go(64'h4000_0000_0000_0000, 64'h0000_0000_4000_0001, 1'b0, "R5");
    go(64'h4000_0000_0000_0000, 64'h0000_0000_8000_0000, 1'b0, "R5");
    go(MINV, ONE, 1'b0, "R5");
    // R6 rounding
    go(64'h0000_0002_0000_0000, 64'h0000_0003_0000_0000, 1'b0, "R6");
    go(64'h0000_0002_0000_0000, 64'h0000_0003_0000_0000, 1'b1, "R6");
    go(-64'h0000_0002_0000_0000, 64'h0000_0003_0000_0000, 1'b1, "R6");
    go(64'h0000_0004_FFFF_FFFF, 64'h0000_0000_0000_0005, 1'b1, "R6");

    // mixed patterns
    s = 64'h9E37_79B9_7F4A_7C15;
    for (int i = 0; i < 16; i++) begin
      logic [63:0] a, b;
      s = s ^ (s << 13); s = s ^ (s >> 7); s = s ^ (s << 17);
      a = $signed(s) >>> s[5:2];
      s = s ^ (s << 13); s = s ^ (s >> 7); s = s ^ (s << 17);
      b = $signed(s) >>> (5'd8 + {1'b0, s[3:0]});
      go(a, b, i[0], "R2");
    end

    // R8: start while busy is ignored
    issue(64'h0000_000A_0000_0000, 64'h0000_0004_0000_0000, 1'b0, "R8");
    repeat (10) @(negedge clk);
    dvd = 64'h0000_0001_0000_0000; dvs = 64'd0; rnd = 1'b1; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    wait_done();
    repeat (80) @(negedge clk);
    chk("R8", "busy after ignored start", {63'd0, busy}, 64'd0);

    // R9: start accepted in the done cycle
    issue(64'h0000_0003_0000_0000, 64'h0000_0002_0000_0000, 1'b0, "R9");
    wait_done();
    issue(-64'h0000_0009_0000_0000, 64'h0000_0004_0000_0000, 1'b0, "R9");
    wait_done();
    @(negedge clk);
    chk("R9", "scoreboard empty", 64'(sb_q.size()), 64'd0);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule